// File: doc/BRIEF.md
# Compressed Bundle Slot Expander

This block sits between an instruction fetch buffer and a row of per-unit decoders in a wide-issue core. Compilers for such cores leave empty issue slots out of the stored program to save space. Each bundle therefore arrives in packed form, and this block rebuilds the full instruction word. Every functional unit gets its own fixed slot, and every slot that has no stored operation is filled with the all-zero no-op word.

The packing scheme is fixed at build time by a parameter and takes one of three values. The first is a raw scheme, in which the word is already full width. The second is a header-mask scheme, in which a small presence mask comes first and the stored operations follow it. The third is a chained-record scheme, in which every stored operation carries one continuation bit. The block also reports how many input bits the bundle used, so the fetch logic can advance its pointer. Input and output both use a valid/ready handshake, and the output is held in a register.

Top module: `vliw_expander`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `outValid` is 0 and `inReady` is 1.
- R2: Raw scheme (FORMAT = FMT_RAW): `slotOps` equals bits [NUM_SLOTS*OP_W-1:0] of the bundle, all `slotValid` bits are 1, and `consumedBits` is NUM_SLOTS*OP_W.
- R3: Header-mask scheme (FORMAT = FMT_MASK): bit s of the bundle's low NUM_SLOTS bits marks slot s as present. The stored operations start at bit NUM_SLOTS and are packed OP_W bits apart in ascending slot order. A present slot s receives the stored operation whose index is the number of present slots below s, so a lone operation for the top slot comes from the first packed position.
- R4: Header-mask scheme: `consumedBits` is NUM_SLOTS + OP_W times the number of present slots. A mask of all zeros gives an all-no-op word and consumes only the header.
- R5: Chained-record scheme (FORMAT = FMT_MARK): record r occupies bits [r*(OP_W+1) +: OP_W+1]. Its bit 0 is the continuation bit (1 = another record follows, 0 = last record), and its upper OP_W bits are the operation. The record count ends at the first continuation bit of 0 and is capped at NUM_SLOTS. `consumedBits` is the record count times (OP_W+1).
- R6: Chained-record scheme: the top log2(NUM_SLOTS) bits of an operation name its target slot. Slot s receives the first record whose target field equals s, and any later record naming the same slot is dropped.
- R7: Every slot without a stored operation outputs all zeros with its `slotValid` bit at 0.
- R8: A bundle is taken on a clock edge where `inValid` and `inReady` are both 1, and its expansion appears on the outputs with `outValid` at 1 after that edge. `outValid` falls after an edge with `outReady` at 1 and no new bundle taken.
- R9: While `outValid` is 1 and `outReady` is 0, `inReady` is 0 and all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Bundle on `bundleIn` is offered |
| inReady | output | 1 | Block can take a bundle this cycle |
| bundleIn | input | NUM_SLOTS*(OP_W+1) | Packed bundle, bit 0 first |
| outValid | output | 1 | Expanded word is present |
| outReady | input | 1 | Decoders take the expanded word |
| slotOps | output | NUM_SLOTS*OP_W | Slot s in bits [s*OP_W +: OP_W] |
| slotValid | output | NUM_SLOTS | Slot holds a stored operation |
| consumedBits | output | $clog2(NUM_SLOTS*(OP_W+1)+1) | Bits used by the bundle |

## Verification
The bench builds three copies of the block with four 32-bit slots, one for each packing scheme, and feeds the same bundle stream to all of them. One stream therefore checks the mask-popcount routing, the chained-record count and its cap, the target-field steering with duplicate targets, and raw pass-through side by side. Four slots are enough for masks with gaps, an empty mask, a full mask, and all four continuation bits set to 1. Random gaps in the stream and random backpressure cover the hold and re-accept timing.

// File: rtl/expander_pkg.sv
package expander_pkg;
  typedef enum logic [1:0] {
    FMT_RAW  = 2'd0,
    FMT_MASK = 2'd1,
    FMT_MARK = 2'd2
  } bundleFmt_e;

  typedef struct packed {
    logic load;
    logic drop;
  } ctrlStrobe_t;
endpackage

// File: rtl/expander_ctrl.sv
module expander_ctrl
  import expander_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output ctrlStrobe_t strobe
);
  logic validQ;

  // Room for a new bundle when empty or when the held word leaves now.
  assign inReady     = !validQ || outReady;
  assign strobe.load = inValid && inReady;
  assign strobe.drop = validQ && outReady && !strobe.load;
  assign outValid    = validQ;

  always_ff @(posedge clk) begin
    if (!rst_n)           validQ <= 1'b0;
    else if (strobe.load) validQ <= 1'b1;
    else if (strobe.drop) validQ <= 1'b0;
  end
endmodule

// File: rtl/expander_datapath.sv
module expander_datapath
  import expander_pkg::*;
#(
  parameter int         NUM_SLOTS = 4,
  parameter int         OP_W      = 32,
  parameter bundleFmt_e FORMAT    = FMT_MASK,
  localparam int RAW_W    = NUM_SLOTS * OP_W,
  localparam int REC_W    = OP_W + 1,
  localparam int BUNDLE_W = NUM_SLOTS * REC_W,
  localparam int CNT_W    = $clog2(BUNDLE_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrlStrobe_t         strobe,
  input  logic [BUNDLE_W-1:0] bundleIn,
  output logic [RAW_W-1:0]    slotOps,
  output logic [NUM_SLOTS-1:0] slotValid,
  output logic [CNT_W-1:0]    consumedBits
);
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [RAW_W-1:0]     nextOps;
  logic [NUM_SLOTS-1:0] nextValid;
  logic [CNT_W-1:0]     nextCons;

  generate
    if (FORMAT == FMT_RAW) begin : g_raw
      logic unusedTail;
      assign unusedTail = ^bundleIn[BUNDLE_W-1:RAW_W];
      always_comb begin
        nextOps   = bundleIn[RAW_W-1:0];
        nextValid = '1;
        nextCons  = CNT_W'(RAW_W);
      end
    end else if (FORMAT == FMT_MASK) begin : g_mask
      always_comb begin
        int packIdx;
        nextOps   = '0;
        nextValid = '0;
        packIdx   = 0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
          if (bundleIn[s]) begin
            nextOps[s*OP_W +: OP_W] = bundleIn[NUM_SLOTS + packIdx*OP_W +: OP_W];
            nextValid[s] = 1'b1;
            packIdx++;
          end
        end
        nextCons = CNT_W'(NUM_SLOTS + packIdx*OP_W);
      end
    end else begin : g_mark
      always_comb begin
        int          recCount;
        logic        chainEnd;
        logic        taken;
        logic [IDX_W-1:0] target;
        nextOps   = '0;
        nextValid = '0;
        recCount  = 0;
        chainEnd  = 1'b0;
        for (int r = 0; r < NUM_SLOTS; r++) begin
          if (!chainEnd) begin
            recCount = r + 1;
            chainEnd = !bundleIn[r*REC_W];
          end
        end
        for (int s = 0; s < NUM_SLOTS; s++) begin
          taken = 1'b0;
          for (int r = 0; r < NUM_SLOTS; r++) begin
            target = bundleIn[r*REC_W + 1 + OP_W - IDX_W +: IDX_W];
            if (r < recCount && !taken && target == IDX_W'(s)) begin
              nextOps[s*OP_W +: OP_W] = bundleIn[r*REC_W + 1 +: OP_W];
              nextValid[s] = 1'b1;
              taken = 1'b1;
            end
          end
        end
        nextCons = CNT_W'(recCount * REC_W);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slotOps      <= '0;
      slotValid    <= '0;
      consumedBits <= '0;
    end else if (strobe.load) begin
      slotOps      <= nextOps;
      slotValid    <= nextValid;
      consumedBits <= nextCons;
    end
  end
endmodule

// File: rtl/vliw_expander.sv
module vliw_expander
  import expander_pkg::*;
#(
  parameter int         NUM_SLOTS = 4,
  parameter int         OP_W      = 32,
  parameter bundleFmt_e FORMAT    = FMT_MASK,
  localparam int RAW_W    = NUM_SLOTS * OP_W,
  localparam int BUNDLE_W = NUM_SLOTS * (OP_W + 1),
  localparam int CNT_W    = $clog2(BUNDLE_W + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic [BUNDLE_W-1:0]  bundleIn,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [RAW_W-1:0]     slotOps,
  output logic [NUM_SLOTS-1:0] slotValid,
  output logic [CNT_W-1:0]     consumedBits
);
  ctrlStrobe_t strobe;

  expander_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .strobe(strobe)
  );

  expander_datapath #(.NUM_SLOTS(NUM_SLOTS), .OP_W(OP_W), .FORMAT(FORMAT)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .bundleIn(bundleIn),
    .slotOps(slotOps), .slotValid(slotValid), .consumedBits(consumedBits)
  );
endmodule

// File: rtl/expander_chk.sv
module expander_chk
  import expander_pkg::*;
#(
  parameter int         NUM_SLOTS = 4,
  parameter int         OP_W      = 32,
  parameter bundleFmt_e FORMAT    = FMT_MASK,
  localparam int RAW_W    = NUM_SLOTS * OP_W,
  localparam int REC_W    = OP_W + 1,
  localparam int BUNDLE_W = NUM_SLOTS * REC_W,
  localparam int CNT_W    = $clog2(BUNDLE_W + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 inValid,
  input logic                 inReady,
  input logic [BUNDLE_W-1:0]  bundleIn,
  input logic                 outValid,
  input logic                 outReady,
  input logic [RAW_W-1:0]     slotOps,
  input logic [NUM_SLOTS-1:0] slotValid,
  input logic [CNT_W-1:0]     consumedBits
);
  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> !outValid);

  assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady |=> outValid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid && $stable(slotOps) && $stable(slotValid)
                               && $stable(consumedBits));

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assert_nop_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        outValid && !slotValid[s] |-> slotOps[s*OP_W +: OP_W] == '0);
    end
    if (FORMAT == FMT_RAW) begin : g_raw
      assert_raw_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        outValid |-> &slotValid && consumedBits == CNT_W'(RAW_W));
    end else if (FORMAT == FMT_MASK) begin : g_mask
      assert_mask_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        outValid |-> consumedBits == CNT_W'(NUM_SLOTS + $countones(slotValid) * OP_W));
    end else begin : g_mark
      assert_mark_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        outValid |-> consumedBits != '0 && (consumedBits % REC_W) == 0
                     && consumedBits <= CNT_W'(BUNDLE_W));
    end
  endgenerate
endmodule

bind vliw_expander expander_chk #(.NUM_SLOTS(NUM_SLOTS), .OP_W(OP_W), .FORMAT(FORMAT)) chk_i (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady), .bundleIn(bundleIn),
  .outValid(outValid), .outReady(outReady), .slotOps(slotOps), .slotValid(slotValid),
  .consumedBits(consumedBits)
);

// File: tb/vliw_expander_tb_top.sv
`timescale 1ns/100ps
module vliw_expander_tb_top;
  import expander_pkg::*;
  localparam int NS = 4;
  localparam int OW = 32;
  localparam int RW = OW + 1;
  localparam int BW = NS * RW;
  localparam int CW = $clog2(BW + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic outReady = 1'b0;
  logic [BW-1:0] bundleIn = '0;

  logic          gotReady [3];
  logic          gotValid [3];
  logic [NS*OW-1:0] gotOps [3];
  logic [NS-1:0] gotSv [3];
  logic [CW-1:0] gotCons [3];

  int checks = 0;
  int fails = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  // index 0 = header-mask, 1 = raw, 2 = chained-record
  vliw_expander #(.NUM_SLOTS(NS), .OP_W(OW), .FORMAT(FMT_MASK)) dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(gotReady[0]), .bundleIn(bundleIn),
    .outValid(gotValid[0]), .outReady(outReady), .slotOps(gotOps[0]), .slotValid(gotSv[0]),
    .consumedBits(gotCons[0]));
  vliw_expander #(.NUM_SLOTS(NS), .OP_W(OW), .FORMAT(FMT_RAW)) dutRaw_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(gotReady[1]), .bundleIn(bundleIn),
    .outValid(gotValid[1]), .outReady(outReady), .slotOps(gotOps[1]), .slotValid(gotSv[1]),
    .consumedBits(gotCons[1]));
  vliw_expander #(.NUM_SLOTS(NS), .OP_W(OW), .FORMAT(FMT_MARK)) dutMark_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(gotReady[2]), .bundleIn(bundleIn),
    .outValid(gotValid[2]), .outReady(outReady), .slotOps(gotOps[2]), .slotValid(gotSv[2]),
    .consumedBits(gotCons[2]));

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %h expected %h", tag, what, $time, act, exp);
    end
  endtask

  // Reference expansion, written from the requirements.
  function automatic void expand(input int fmt, input logic [BW-1:0] b,
                                 output logic [NS*OW-1:0] o, output logic [NS-1:0] v,
                                 output int c);
    int k;
    int n;
    logic [OW-1:0] op;
    o = '0; v = '0; c = 0;
    if (fmt == 1) begin
      o = b[NS*OW-1:0]; v = '1; c = NS * OW;
    end else if (fmt == 0) begin
      k = 0;
      for (int s = 0; s < NS; s++)
        if (b[s]) begin o[s*OW +: OW] = b[NS + k*OW +: OW]; v[s] = 1'b1; k++; end
      c = NS + k * OW;
    end else begin
      n = NS;
      for (int r = NS - 1; r >= 0; r--) if (!b[r*RW]) n = r + 1;
      for (int r = 0; r < n; r++) begin
        op = b[r*RW + 1 +: OW];
        if (!v[op[OW-1 -: 2]]) begin
          v[op[OW-1 -: 2]] = 1'b1;
          o[op[OW-1 -: 2]*OW +: OW] = op;
        end
      end
      c = n * RW;
    end
  endfunction

  bit mValid = 0;
  logic [NS*OW-1:0] eOps [3];
  logic [NS-1:0] eSv [3];
  int eCons [3];

  always @(posedge clk) begin
    if (!rst_n) mValid = 0;
    else if (inValid && (!mValid || outReady)) begin
      for (int f = 0; f < 3; f++) expand(f, bundleIn, eOps[f], eSv[f], eCons[f]);
      mValid = 1;
    end else if (outReady) mValid = 0;
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (started) begin
      for (int f = 0; f < 3; f++) begin
        check(gotReady[f] == (!mValid || outReady), "R9", "inReady",
              BW'(gotReady[f]), BW'(!mValid || outReady));
        check(gotValid[f] == mValid, "R8", "outValid", BW'(gotValid[f]), BW'(mValid));
        if (mValid) begin
          check(gotOps[f] == eOps[f], f == 1 ? "R2" : (f == 0 ? "R3" : "R6"), "slotOps",
                BW'(gotOps[f]), BW'(eOps[f]));
          check(gotSv[f] == eSv[f], "R7", "slotValid", BW'(gotSv[f]), BW'(eSv[f]));
          check(int'(gotCons[f]) == eCons[f], f == 1 ? "R2" : (f == 0 ? "R4" : "R5"),
                "consumedBits", BW'(gotCons[f]), BW'(eCons[f]));
        end
      end
    end
  end

  task automatic send(input logic [BW-1:0] b, input bit rdy);
    @(negedge clk); #0.5;
    inValid = 1'b1; bundleIn = b; outReady = rdy;
    #0.5;
    while (!gotReady[0]) begin
      @(negedge clk); #0.5;
      outReady = 1'b1;
      #0.5;
    end
    @(posedge clk);
  endtask

  task automatic idle(input bit rdy);
    @(negedge clk); #0.5;
    inValid = 1'b0; outReady = rdy;
    @(posedge clk);
  endtask

  function automatic logic [BW-1:0] mkMask(input logic [NS-1:0] m, input logic [NS*OW-1:0] packed_ops);
    logic [BW-1:0] b;
    b = '0;
    b[NS-1:0] = m;
    b[NS +: NS*OW] = packed_ops;
    return b;
  endfunction

  function automatic logic [BW-1:0] mkRec(input int n, input logic [NS*OW-1:0] ops, input bit allOnes);
    logic [BW-1:0] b;
    b = '0;
    for (int r = 0; r < NS; r++) begin
      b[r*RW + 1 +: OW] = (r < n) ? ops[r*OW +: OW] : '0;
      b[r*RW] = allOnes ? 1'b1 : (r < n - 1);
    end
    return b;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int f = 0; f < 3; f++) begin
      check(gotValid[f] == 1'b0, "R1", "outValid in reset", BW'(gotValid[f]), '0);
      check(gotReady[f] == 1'b1, "R1", "inReady in reset", BW'(gotReady[f]), BW'(1));
    end
    #0.5 rst_n = 1'b1;
    @(negedge clk);
    for (int f = 0; f < 3; f++)
      check(gotValid[f] == 1'b0, "R1", "outValid after reset", BW'(gotValid[f]), '0);
    started = 1;

    // R3/R4: mask with a gap, empty mask, full mask, lone top slot
    send(mkMask(4'b1011, {32'h0, 32'hC0DE_0003, 32'hB0B0_0001, 32'hA1A1_0000}), 1);
    send(mkMask(4'b0000, {4{32'hFFFF_FFFF}}), 1);
    send(mkMask(4'b1111, {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111}), 1);
    send(mkMask(4'b1000, {32'h0, 32'h0, 32'hDEAD_0000, 32'h5151_5151}), 1);
    // R5/R6: three records steered by target field, single record, all chain bits set
    send(mkRec(3, {32'h0, 32'hC000_0033, 32'h8000_0022, 32'h0000_0011}, 0), 1);
    send(mkRec(1, {32'h0, 32'h0, 32'h0, 32'hC123_4567}, 0), 1);
    send(mkRec(4, {32'hC000_0004, 32'h8000_0003, 32'h4000_0002, 32'h0000_0001}, 1), 1);
    // R6: duplicate target, first wins
    send(mkRec(2, {32'h0, 32'h0, 32'h4000_00BB, 32'h4000_00AA}, 0), 1);
    // R9: hold under backpressure
    send(mkMask(4'b0110, {64'h0, 32'h7777_0000, 32'h6666_0000}), 0);
    repeat (4) idle(0);
    send(mkMask(4'b0001, {96'h0, 32'h9999_0000}), 0);
    idle(1);
    idle(1);
    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [BW-1:0] rb;
      rb = {$urandom, $urandom, $urandom, $urandom, $urandom};
      if ($urandom % 4 == 0) idle($urandom % 3 != 0);
      else send(rb, $urandom % 3 != 0);
    end
    repeat (3) idle(1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule